// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits between one requester and its cache request queue and arbitrates two kinds of atomic sequence. For the reserved-load / conditional-store pair, the completion of a reserved load records a reservation on its cache line, tagged with the id that issued the load. A later conditional store is judged in the same cycle it is presented. It goes forward, and consumes the reservation, only if the reservation is live, covers the same line and carries the same id. Otherwise the store is dropped and a failure code is returned. The decision and the consumption happen in one clock edge, so no other request can reach the line in between.

For read-modify-write pairs, the completion of the read phase fences the line: any later request to that line except the write phase is answered with a retry code and is not forwarded. The completion of the matching write phase lifts the fence. An external invalidate naming the reserved line kills the reservation, and it already counts against a conditional store presented in the same cycle.

Each request gets a response one cycle after it is presented. A forwarded request also appears on the issue outputs in that same cycle, with a flag marking it as atomic-class.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, no response, no issue, no reservation and no fenced line are reported.
- R2: A reserved-load completion (cpl_kind 3) sets the reservation to its line and id one cycle later, and overwrites any earlier reservation.
- R3: A conditional store (req_kind 4) whose line and id match a live reservation gets rsp_code 0 (issued), is forwarded with iss_atomic 1, and clears the reservation.
- R4: A conditional store with no reservation, another line or another id gets rsp_code 1 (failed), is not forwarded, and leaves the reservation unchanged.
- R5: An invalidate on the reserved line clears the reservation, and an invalidate on another line has no effect. A conditional store presented in the same cycle as an invalidate of its line fails.
- R6: A read-modify-write read completion (cpl_kind 5) fences its line. A write-phase completion (cpl_kind 6) on that line lifts the fence, and one on another line does not.
- R7: While a line is fenced, any request to it other than kind 6 gets rsp_code 2 (retry), is not forwarded, and does not consume a reservation. Requests to other lines and kind 6 to the fenced line are forwarded.
- R8: Every request gets rsp_valid one cycle later. A forwarded request shows iss_valid with iss_line. iss_atomic is 1 for kinds 3 to 6 and 0 for kinds 0 (load), 1 (fetch) and 2 (store).
- R9: A conditional store presented in the same cycle as a reserved-load completion is judged on the earlier reservation, and the new reservation remains afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 3 | Request kind: 0 load, 1 fetch, 2 store, 3 reserved load, 4 conditional store, 5 rmw read, 6 rmw write |
| req_line | input | LINE_W | Line address of the request |
| req_id | input | ID_W | Requester id of the request |
| cpl_valid | input | 1 | A completion arrives this cycle |
| cpl_kind | input | 3 | Kind of the completing request (same encoding) |
| cpl_line | input | LINE_W | Line address of the completion |
| cpl_id | input | ID_W | Requester id of the completion |
| inv_valid | input | 1 | Invalidate a line this cycle |
| inv_line | input | LINE_W | Line address to invalidate |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 0 issued, 1 conditional store failed, 2 retry |
| iss_valid | output | 1 | Request forwarded to the queue |
| iss_atomic | output | 1 | Forwarded request is atomic-class |
| iss_line | output | LINE_W | Line of the forwarded request |
| resv_held | output | 1 | A reservation is live |
| resv_line | output | LINE_W | Reserved line |
| resv_id | output | ID_W | Owner id of the reservation |
| blk_held | output | 1 | A line is fenced |
| blk_line | output | LINE_W | Fenced line |

## Verification
Within a single clock, the conditional-store judgement can coincide with a change to the reservation: an invalidate of the same line, or a reserved-load completion that replaces the reservation. The bench drives both collisions on purpose. With the invalidate it expects a failure code. With the completion it expects the store to be judged on the old reservation and the new one to survive. A third collision, a fenced line meeting a conditional store that would otherwise pass, must return retry and leave the reservation in place. A random phase over a handful of lines then raises such overlaps often, and the reference model judges every cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam logic [2:0] K_LOAD   = 3'd0;
  localparam logic [2:0] K_FETCH  = 3'd1;
  localparam logic [2:0] K_STORE  = 3'd2;
  localparam logic [2:0] K_LL     = 3'd3;
  localparam logic [2:0] K_SC     = 3'd4;
  localparam logic [2:0] K_RMW_RD = 3'd5;
  localparam logic [2:0] K_RMW_WR = 3'd6;

  localparam logic [1:0] C_ISSUED  = 2'd0;
  localparam logic [1:0] C_SC_FAIL = 2'd1;
  localparam logic [1:0] C_RETRY   = 2'd2;

  // atomic-class kinds sit in one contiguous range of the encoding
  function automatic logic kind_atomic(input logic [2:0] k);
    return (k >= K_LL) && (k <= K_RMW_WR);
  endfunction

  // a fenced line lets only the write phase through
  function automatic logic kind_passes_fence(input logic [2:0] k);
    return k == K_RMW_WR;
  endfunction
endpackage

// File: rtl/rsv_slot.sv
module rsv_slot #(
  parameter int LINE_W = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic [ID_W-1:0]   set_id,
  input  logic              inv_en,
  input  logic [LINE_W-1:0] inv_line,
  input  logic              take_en,
  output logic              held,
  output logic [LINE_W-1:0] line,
  output logic [ID_W-1:0]   id,
  output logic              inv_hit
);
  assign inv_hit = inv_en && held && (inv_line == line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      line <= '0;
      id   <= '0;
    end else if (set_en) begin
      held <= 1'b1;
      line <= set_line;
      id   <= set_id;
    end else if (inv_hit || take_en) begin
      held <= 1'b0;
    end
  end

  AST_INV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit && !set_en |=> !held); // R5
  AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    take_en && !set_en |=> !held); // R3
  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> held && line == $past(set_line) && id == $past(set_id)); // R2
endmodule

// File: rtl/rsv_line_block.sv
module rsv_line_block #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fence_en,
  input  logic              lift_en,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              held,
  output logic [LINE_W-1:0] line
);
  logic lift_hit;
  assign lift_hit = lift_en && held && (cpl_line == line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      line <= '0;
    end else if (fence_en) begin
      held <= 1'b1;
      line <= cpl_line;
    end else if (lift_hit) begin
      held <= 1'b0;
    end
  end

  AST_FENCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fence_en |=> held && line == $past(cpl_line)); // R6
  AST_FENCE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    held && !fence_en && !(lift_en && cpl_line == line) |=> held); // R6
endmodule

// File: rtl/rsv_judge.sv
module rsv_judge
  import rsv_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 4
) (
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic              resv_live,
  input  logic [LINE_W-1:0] resv_line,
  input  logic [ID_W-1:0]   resv_id,
  input  logic              blk_held,
  input  logic [LINE_W-1:0] blk_line,
  output logic [1:0]        code,
  output logic              go,
  output logic              sc_pass
);
  logic fenced, owns;
  assign fenced = blk_held && (blk_line == req_line) && !kind_passes_fence(req_kind);
  assign owns   = resv_live && (resv_line == req_line) && (resv_id == req_id);

  always_comb begin
    code    = C_ISSUED;
    sc_pass = 1'b0;
    if (fenced) begin
      code = C_RETRY;
    end else if (req_kind == K_SC) begin
      sc_pass = owns;
      code    = owns ? C_ISSUED : C_SC_FAIL;
    end
  end

  assign go = req_valid && (code == C_ISSUED);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import rsv_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic              inv_valid,
  input  logic [LINE_W-1:0] inv_line,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              iss_valid,
  output logic              iss_atomic,
  output logic [LINE_W-1:0] iss_line,
  output logic              resv_held,
  output logic [LINE_W-1:0] resv_line,
  output logic [ID_W-1:0]   resv_id,
  output logic              blk_held,
  output logic [LINE_W-1:0] blk_line
);
  // named internal events
  logic ll_done, rmw_rd_done, rmw_wr_done;
  logic inv_hit, sc_pass, take, go;
  logic [1:0] code;

  assign ll_done     = cpl_valid && (cpl_kind == K_LL);
  assign rmw_rd_done = cpl_valid && (cpl_kind == K_RMW_RD);
  assign rmw_wr_done = cpl_valid && (cpl_kind == K_RMW_WR);
  assign take        = req_valid && sc_pass;

  rsv_slot #(.LINE_W(LINE_W), .ID_W(ID_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .set_en(ll_done), .set_line(cpl_line), .set_id(cpl_id),
    .inv_en(inv_valid), .inv_line(inv_line), .take_en(take),
    .held(resv_held), .line(resv_line), .id(resv_id), .inv_hit(inv_hit)
  );

  rsv_line_block #(.LINE_W(LINE_W)) u_fence (
    .clk(clk), .rst_n(rst_n),
    .fence_en(rmw_rd_done), .lift_en(rmw_wr_done), .cpl_line(cpl_line),
    .held(blk_held), .line(blk_line)
  );

  rsv_judge #(.LINE_W(LINE_W), .ID_W(ID_W)) u_judge (
    .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line), .req_id(req_id),
    .resv_live(resv_held && !inv_hit), .resv_line(resv_line), .resv_id(resv_id),
    .blk_held(blk_held), .blk_line(blk_line),
    .code(code), .go(go), .sc_pass(sc_pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= C_ISSUED;
      iss_valid  <= 1'b0;
      iss_atomic <= 1'b0;
      iss_line   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_code   <= req_valid ? code : C_ISSUED;
      iss_valid  <= go;
      iss_atomic <= go && kind_atomic(req_kind);
      iss_line   <= go ? req_line : '0;
    end
  end

  AST_NO_ISSUE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == C_SC_FAIL |-> !iss_valid); // R4
  AST_NO_ISSUE_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == C_RETRY |-> !iss_valid); // R7
  AST_ISSUE_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> rsp_valid && rsp_code == C_ISSUED); // R8
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_INV_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == K_SC && inv_valid && inv_line == req_line
    && !(blk_held && blk_line == req_line) |=> rsp_code == C_SC_FAIL); // R5
  AST_RETRY_KEEPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    resv_held && req_valid && blk_held && blk_line == req_line && req_kind == K_SC
    && !inv_hit |=> resv_held); // R7
endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int LW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, cpl_valid = 0, inv_valid = 0;
  logic [2:0] req_kind = 0, cpl_kind = 0;
  logic [LW-1:0] req_line = 0, cpl_line = 0, inv_line = 0;
  logic [IW-1:0] req_id = 0, cpl_id = 0;
  logic rsp_valid, iss_valid, iss_atomic, resv_held, blk_held;
  logic [1:0] rsp_code;
  logic [LW-1:0] iss_line, resv_line, blk_line;
  logic [IW-1:0] resv_id;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  llsc_monitor #(.LINE_W(LW), .ID_W(IW)) i_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line), .req_id(req_id),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_line(cpl_line), .cpl_id(cpl_id),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .iss_valid(iss_valid),
    .iss_atomic(iss_atomic), .iss_line(iss_line),
    .resv_held(resv_held), .resv_line(resv_line), .resv_id(resv_id),
    .blk_held(blk_held), .blk_line(blk_line)
  );

  // behavioural reference
  bit m_rv, m_rh, m_bh, m_iss, m_atom;
  int m_code, m_rl, m_ri, m_bl, m_il;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv = 0; m_rh = 0; m_bh = 0; m_iss = 0; m_atom = 0;
      m_code = 0; m_rl = 0; m_ri = 0; m_bl = 0; m_il = 0;
    end else begin
      bit live, pass, fenced;
      int code;
      live   = m_rh && !(inv_valid && int'(inv_line) == m_rl);
      fenced = m_bh && m_bl == int'(req_line) && req_kind != 3'd6;
      pass = 0; code = 0;
      if (req_valid) begin
        if (fenced) code = 2;
        else if (req_kind == 3'd4) begin
          pass = live && m_rl == int'(req_line) && m_ri == int'(req_id);
          code = pass ? 0 : 1;
        end
      end
      m_rv = req_valid;
      m_code = code;
      m_iss = req_valid && code == 0;
      m_atom = m_iss && req_kind inside {3'd3, 3'd4, 3'd5, 3'd6};
      m_il = m_iss ? int'(req_line) : 0;
      if (cpl_valid && cpl_kind == 3'd3) begin
        m_rh = 1; m_rl = int'(cpl_line); m_ri = int'(cpl_id);
      end else if (!live || pass) m_rh = 0;
      if (cpl_valid && cpl_kind == 3'd5) begin
        m_bh = 1; m_bl = int'(cpl_line);
      end else if (cpl_valid && cpl_kind == 3'd6 && m_bh && m_bl == int'(cpl_line)) m_bh = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 rsp_valid", int'(rsp_valid), int'(m_rv));
      check("R3 rsp_code", int'(rsp_code), m_code);
      check("R8 iss_valid", int'(iss_valid), int'(m_iss));
      check("R8 iss_atomic", int'(iss_atomic), int'(m_atom));
      check("R8 iss_line", int'(iss_line), m_il);
      check("R2 resv_held", int'(resv_held), int'(m_rh));
      if (m_rh) begin
        check("R2 resv_line", int'(resv_line), m_rl);
        check("R2 resv_id", int'(resv_id), m_ri);
      end
      check("R6 blk_held", int'(blk_held), int'(m_bh));
      if (m_bh) check("R6 blk_line", int'(blk_line), m_bl);
    end
  end

  task automatic cyc(bit rv, logic [2:0] rk, int rl, int ri,
                     bit cv, logic [2:0] ck, int cl, int ci, bit iv, int il);
    req_valid = rv; req_kind = rk; req_line = LW'(rl); req_id = IW'(ri);
    cpl_valid = cv; cpl_kind = ck; cpl_line = LW'(cl); cpl_id = IW'(ci);
    inv_valid = iv; inv_line = LW'(il);
    @(negedge clk);
    req_valid = 0; cpl_valid = 0; inv_valid = 0;
  endtask
  task automatic rq(logic [2:0] k, int l, int i); cyc(1, k, l, i, 0, 0, 0, 0, 0, 0); endtask
  task automatic cp(logic [2:0] k, int l, int i); cyc(0, 0, 0, 0, 1, k, l, i, 0, 0); endtask
  task automatic iv(int l); cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, l); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 iss_valid", int'(iss_valid), 0);
    check("R1 resv_held", int'(resv_held), 0);
    check("R1 blk_held", int'(blk_held), 0);

    rq(3'd0, 5, 1);
    check("R8 load issued", int'(iss_valid), 1);
    check("R8 load not atomic", int'(iss_atomic), 0);
    cp(3'd3, 10, 1);
    check("R2 set", int'(resv_held), 1);
    check("R2 line", int'(resv_line), 10);
    rq(3'd4, 10, 2);
    check("R4 other id", int'(rsp_code), 1);
    check("R4 no issue", int'(iss_valid), 0);
    check("R4 kept", int'(resv_held), 1);
    rq(3'd4, 11, 1);
    check("R4 other line", int'(rsp_code), 1);
    rq(3'd4, 10, 1);
    check("R3 pass", int'(rsp_code), 0);
    check("R3 atomic", int'(iss_atomic), 1);
    check("R3 consumed", int'(resv_held), 0);
    rq(3'd4, 10, 1);
    check("R4 none held", int'(rsp_code), 1);

    cp(3'd3, 20, 3);
    cp(3'd3, 21, 3);
    check("R2 overwrite", int'(resv_line), 21);
    iv(22);
    check("R5 other line kept", int'(resv_held), 1);
    iv(21);
    check("R5 cleared", int'(resv_held), 0);
    cp(3'd3, 30, 1);
    cyc(1, 3'd4, 30, 1, 0, 0, 0, 0, 1, 30);
    check("R5 same-cycle inv fails", int'(rsp_code), 1);

    cyc(1, 3'd4, 40, 1, 1, 3'd3, 40, 1, 0, 0);
    check("R9 judged on old", int'(rsp_code), 1);
    check("R9 new stands", int'(resv_held), 1);
    rq(3'd4, 40, 1);
    check("R9 then passes", int'(rsp_code), 0);

    cp(3'd5, 50, 0);
    check("R6 fenced", int'(blk_held), 1);
    rq(3'd0, 50, 0);
    check("R7 retry", int'(rsp_code), 2);
    check("R7 no issue", int'(iss_valid), 0);
    rq(3'd2, 51, 0);
    check("R7 other line", int'(iss_valid), 1);
    rq(3'd6, 50, 0);
    check("R7 write phase passes", int'(iss_valid), 1);
    cp(3'd6, 51, 0);
    check("R6 other lift ignored", int'(blk_held), 1);
    cp(3'd6, 50, 0);
    check("R6 lifted", int'(blk_held), 0);
    rq(3'd0, 50, 0);
    check("R7 after lift", int'(rsp_code), 0);

    cp(3'd3, 60, 1);
    cp(3'd5, 60, 1);
    rq(3'd4, 60, 1);
    check("R7 sc retried", int'(rsp_code), 2);
    check("R7 resv kept", int'(resv_held), 1);
    cp(3'd6, 60, 1);

    for (int n = 0; n < 600; n++)
      cyc($urandom_range(0, 1), 3'($urandom_range(0, 6)), $urandom_range(0, 3), $urandom_range(0, 1),
          $urandom_range(0, 1), 3'($urandom_range(0, 6)), $urandom_range(0, 3), $urandom_range(0, 1),
          ($urandom_range(0, 5) == 0), $urandom_range(0, 3));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule